// File: doc/BRIEF.md
# Toggle-Handshake Single-Port Memory

This block is a synchronous single-port word memory for a scheduled datapath controller. The controller does not raise a level strobe to start an access. It writes a new value into its request token, so that the token differs from the acknowledge token, which the memory owns. On the next rising clock edge the memory serves the request. It performs a write when the write-enable input is high and a read when it is low. In that same edge it copies the request token into its acknowledge register, so the two tokens match again and the memory is idle.

Tokens are compared over their full width. Any value that differs from the acknowledge token is a new request, so the controller can use a counter, a single flipped bit or any other change. Because each access completes in one edge, the block has no valid/ready pair and no back-pressure. A request is always taken in the edge that follows it. The acknowledge token and the read-data register are outputs the client only reads. The address is reduced modulo the depth, which must be a power of two.

Top module: `tgl_ram`

## Requirements
- R1: While reset is asserted (rst_n low), the acknowledge token and the read data are both zero.
- R2: When the request token equals the acknowledge token, an edge leaves the storage, the read data and the acknowledge token unchanged, whatever the address, data and write-enable inputs are.
- R3: When the tokens differ and wr_en is 1, the edge stores wdata into the word selected by the address.
- R4: When the tokens differ and wr_en is 0, the edge loads the selected word into rdata, which is visible after that edge.
- R5: Every edge that serves a request sets the acknowledge token to the request token sampled at that edge.
- R6: A request is served exactly once. Holding the same request token on later edges causes no further write or read.
- R7: Only the low log2(DEPTH) address bits select a word. With DEPTH=16, address 21 reaches word 5.
- R8: rdata keeps its last read value through write edges and idle edges.
- R9: A read issued in the cycle directly after a write to the same word returns the newly written data.
- R10: A token that differs from the acknowledge token only in its most significant bit (bit 31 with the default width) is a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every effect occurs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, taken modulo DEPTH |
| wdata | input | DATA_W | Data to store on a write |
| wr_en | input | 1 | 1 selects a write, 0 selects a read |
| req_tok | input | TOK_W | Request token set by the client; must be 0 during reset |
| ack_tok | output | TOK_W | Acknowledge token owned by the memory |
| rdata | output | DATA_W | Registered result of the last read |

## Verification
Two events meet in one cycle. The acknowledge token catches up with a request on the same edge that the client raises the next one. Both also meet when a write is followed directly by a read of the same word. The bench provokes this by changing the token on every cycle, with writes and reads back to back. A scoreboard item is queued per cycle and compared just after the serving edge. The item holds the acknowledge value and the read data that a behavioural array model expects. Idle cycles with write enable held high are checked later by reading back the words they could have corrupted.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } mem_op_e;
endpackage

// File: rtl/tgl_ram_decode.sv
module tgl_ram_decode
  import tgl_ram_pkg::*;
#(
  parameter int TOK_W = 32
) (
  input  logic [TOK_W-1:0] req_tok,
  input  logic [TOK_W-1:0] ack_tok,
  input  logic             wr_en,
  output mem_op_e          op
);
  // Full-width inequality marks a pending request (R10)
  always_comb begin
    if (req_tok == ack_tok) op = OP_IDLE;
    else if (wr_en)         op = OP_WRITE;
    else                    op = OP_READ;
  end
endmodule

// File: rtl/tgl_ram_ack.sv
module tgl_ram_ack
  import tgl_ram_pkg::*;
#(
  parameter int TOK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mem_op_e          op,
  input  logic [TOK_W-1:0] req_tok,
  output logic [TOK_W-1:0] ack_tok
);
  always_ff @(posedge clk) begin
    if (!rst_n)              ack_tok <= '0;
    else if (op != OP_IDLE)  ack_tok <= req_tok;
  end

  // R5: a served request is acknowledged at that edge
  a_r5_ack_takes_token: assert property (@(posedge clk) disable iff (!rst_n)
    (req_tok != ack_tok) |=> (ack_tok == $past(req_tok)));

  // R2: idle edges leave the acknowledge token alone
  a_r2_idle_ack_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_tok == ack_tok) |=> $stable(ack_tok));
endmodule

// File: rtl/tgl_ram_array.sv
module tgl_ram_array
  import tgl_ram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mem_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  // Address reduced modulo DEPTH (R7)
  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (op == OP_WRITE) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              rdata <= '0;
    else if (op == OP_READ)  rdata <= mem[idx];
  end

  // R3: a write lands in the selected word
  a_r3_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> (mem[$past(idx)] == $past(wdata)));

  // R4: a read presents the selected word after the edge
  a_r4_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> (rdata == $past(mem[idx])));

  // R8: read data holds on write and idle edges
  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ) |=> $stable(rdata));
endmodule

// File: rtl/tgl_ram.sv
module tgl_ram
  import tgl_ram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int TOK_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic [TOK_W-1:0]  req_tok,
  output logic [TOK_W-1:0]  ack_tok,
  output logic [DATA_W-1:0] rdata
);
  mem_op_e op;

  tgl_ram_decode #(.TOK_W(TOK_W)) u_decode (
    .req_tok (req_tok),
    .ack_tok (ack_tok),
    .wr_en   (wr_en),
    .op      (op)
  );

  tgl_ram_ack #(.TOK_W(TOK_W)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .req_tok (req_tok),
    .ack_tok (ack_tok)
  );

  tgl_ram_array #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  // R1: reset clears both registered outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ack_tok == '0 && rdata == '0));

  // R6: once acknowledged, a held token starts no new access
  a_r6_single_service: assert property (@(posedge clk) disable iff (!rst_n)
    (req_tok != ack_tok) ##1 (req_tok == $past(req_tok)) |-> (op == OP_IDLE));
endmodule

// File: tb/tgl_ram_tb.sv
module tgl_ram_tb;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int TOK_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              wr_en = 1'b0;
  logic [TOK_W-1:0]  req_tok = '0;
  logic [TOK_W-1:0]  ack_tok;
  logic [DATA_W-1:0] rdata;

  always #4 clk = ~clk;  // 125 MHz

  tgl_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOK_W(TOK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .req_tok(req_tok), .ack_tok(ack_tok), .rdata(rdata)
  );

  typedef struct {
    logic [TOK_W-1:0]  exp_ack;
    logic [DATA_W-1:0] exp_rd;
    string             tag;
  } item_t;

  item_t             sb_q[$];
  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] model_rd = '0;
  logic [TOK_W-1:0]  model_ack = '0;
  int                errors = 0;
  int                checks = 0;
  bit                done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, model updated, expectation queued
  task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [TOK_W-1:0] tok,
                        input string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; req_tok = tok;
    if (tok != model_ack) begin
      if (we) model[a % DEPTH] = d;
      else    model_rd = model[a % DEPTH];
      model_ack = tok;
    end
    it.exp_ack = model_ack;
    it.exp_rd  = model_rd;
    it.tag     = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare just after each serving edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check({it.tag, " ack"},   64'(ack_tok), 64'(it.exp_ack));
        check({it.tag, " rdata"}, 64'(rdata),   64'(it.exp_rd));
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [TOK_W-1:0] tok;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset ack", 64'(ack_tok), 64'(0));
    check("R1 reset rdata", 64'(rdata), 64'(0));
    rst_n = 1'b1;

    access(1'b1, 8'd3, 32'hAAAA_0003, 32'd1, "R3 write w3");
    access(1'b1, 8'd7, 32'hBBBB_0007, 32'd2, "R3 write w7");
    access(1'b0, 8'd3, 32'h0,         32'd3, "R4 read w3");
    access(1'b0, 8'd7, 32'h0,         32'd4, "R4 read w7");
    access(1'b1, 8'd3, 32'hDEAD_0000, 32'd4, "R2 idle");
    access(1'b1, 8'd7, 32'hDEAD_1111, 32'd4, "R6 held token");
    access(1'b1, 8'd7, 32'hDEAD_2222, 32'd4, "R8 idle keeps rdata");
    access(1'b0, 8'd3, 32'h0,         32'd5, "R2 w3 untouched");
    access(1'b0, 8'd7, 32'h0,         32'd6, "R6 w7 untouched");
    access(1'b1, 8'd21, 32'hCCCC_0021, 32'd7, "R7 write addr21");
    access(1'b1, 8'd9,  32'h1234_5678, 32'd8, "R8 write keeps rdata");
    access(1'b0, 8'd5,  32'h0,         32'd9, "R7 read w5");
    access(1'b1, 8'd5,  32'hD00D_0005, 32'h8000_0009, "R10 msb token write");
    access(1'b0, 8'd5,  32'h0,         32'h0000_0009, "R10 msb token read");
    access(1'b1, 8'd11, 32'hE1E1_000B, 32'd10, "R9 write w11");
    access(1'b0, 8'd11, 32'h0,         32'd11, "R9 read-after-write w11");

    tok = 32'd100;
    for (int i = 0; i < DEPTH; i++) begin
      tok++;
      access(1'b1, ADDR_W'(i), DATA_W'(32'h0101_0101 * (i + 1)), tok, "R3 sweep write");
    end
    for (int i = 0; i < DEPTH; i++) begin
      tok++;
      access(1'b0, ADDR_W'(i + DEPTH), 32'h0, tok, "R5 sweep read");
    end
    access(1'b0, 8'd0, 32'h0, tok, "R5 final idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule